// File: doc/BRIEF.md
# Cross-Lane Backward Permute Unit

This block is the lane-exchange crossbar of a 64-lane SIMD datapath. When an operation is issued, every destination lane picks one source lane and receives that lane's 32-bit value. The destination computes the choice itself, from its own index operand. In permute mode, the index is a byte address. A shared immediate offset is added to it, the two low bits of the sum are dropped, and the result is wrapped to 64 lanes. In shuffle mode, the wavefront is split into power-of-two subsections, and a signed lane number is applied inside each one. A policy bit chooses what happens when that lane number falls outside the subsection: it wraps, or the lane gets its own value back.

An execute mask marks the lanes that take part. A lane outside the mask supplies zero to any reader, and its own result is forced to zero. A half-wave option removes the upper half of the lanes from the active set. Even then, permute-mode wrapping stays at the full lane count.

The control path is a two-state machine. `ST_IDLE` moves to `ST_EMIT` on the LOAD transition (`in_valid` high) and stays put on HOLD (`in_valid` low). `ST_EMIT` stays put on STREAM (`in_valid` high) and returns to `ST_IDLE` on DRAIN (`in_valid` low). The registered result is presented with `out_valid` while the machine is in `ST_EMIT`.

Top module: `xlane_permute`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `out_valid` is 0 and `out_data` is all zero.
- R2: When `in_mode`=0 (permute), destination lane i reads source lane bits [7:2] of the 32-bit sum `in_index[i] + in_offset`, with the offset zero-extended. Index bits above bit 7 and the carries into them have no effect, so negative byte addresses wrap modulo 64 without fault.
- R3: When `in_mode`=1 (shuffle) with `in_oob_own`=0, the source lane number s is the signed 8-bit field `in_index[i][7:0]`, and the upper index bits are ignored. Lane i reads lane base + (s mod W), where W = 2^`in_width_log2`, the modulo is non-negative, and base is i with its low log2(W) bits cleared.
- R4: When `in_mode`=1 with `in_oob_own`=1, a lane whose s is negative or at least W receives its own input value. An in-range s behaves as in R3.
- R5: An `in_width_log2` code above 6 acts as 6, giving one 64-lane subsection.
- R6: A destination lane whose `in_exec` bit is 0 outputs zero.
- R7: A source lane whose `in_exec` bit is 0 supplies zero to every lane that reads it.
- R8: With `in_wave32`=1, lanes 32..63 are inactive (R6 and R7 apply to them). Permute-mode wrapping is still modulo 64, so a read that lands on lanes 32..63 returns zero.
- R9: `out_valid` is 1 exactly one clock after a clock with `in_valid`=1, and 0 after a clock with `in_valid`=0.
- R10: `out_data` keeps its value across a clock with `in_valid`=0.
- R11: In permute mode, `in_oob_own` and `in_width_log2` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid and are sampled on this clock |
| in_data | input | 2048 | Per-lane 32-bit source values, lane i at bits [32i+31:32i] |
| in_index | input | 2048 | Per-lane 32-bit index: a byte address in permute mode, a signed 8-bit lane number in bits [7:0] in shuffle mode |
| in_offset | input | 16 | Shared unsigned byte offset (permute mode) |
| in_exec | input | 64 | Execute mask, one bit per lane |
| in_width_log2 | input | 3 | log2 of the shuffle subsection width |
| in_mode | input | 1 | 0 = permute, 1 = shuffle |
| in_oob_own | input | 1 | Shuffle out-of-range policy: 0 = wrap, 1 = own value |
| in_wave32 | input | 1 | Half-wave operation: upper 32 lanes inactive |
| out_valid | output | 1 | Result is valid |
| out_data | output | 2048 | Per-lane 32-bit results, same layout as `in_data` |

## Verification
The assertions take `in_valid`, `in_exec` and `in_wave32` to be defined at every clock edge after reset. They also assume the operands stay fixed during the sampled cycle, because the inactive-lane property compares the result with the mask from the cycle before. The bench changes inputs only on falling edges and holds them across each rising edge, so these assumptions always hold. Its sweeps cover every width code, including the clamped one, and shuffle lane numbers from well below zero to well above 64. The index bits the design must ignore are filled with pseudo-random values, so results that depended on them would show up.

// File: rtl/xlp_pkg.sv
`timescale 1ns/1ps
package xlp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } xlp_state_e;

    typedef enum logic [0:0] {
        MODE_PERMUTE = 1'b0,
        MODE_SHUFFLE = 1'b1
    } xlp_mode_e;

endpackage

// File: rtl/xlp_ctrl.sv
`timescale 1ns/1ps
module xlp_ctrl
    import xlp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic capture,
    output logic out_valid
);

    xlp_state_e state_q;
    xlp_state_e state_d;

    // next-state selection: LOAD, HOLD, STREAM, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs of the machine
    always_comb begin
        capture   = in_valid && !rst;
        out_valid = (state_q == ST_EMIT);
    end

endmodule

// File: rtl/xlp_lane_route.sv
`timescale 1ns/1ps
module xlp_lane_route #(
    parameter int LANES   = 64,
    parameter int IDX_W   = 32,
    parameter int OFF_W   = 16,
    parameter int SHUF_W  = 8,
    parameter int LANE_ID = 0,
    localparam int LANE_W = $clog2(LANES),
    localparam int WL_W   = $clog2(LANE_W + 1)
) (
    input  logic [IDX_W-1:0]  index,
    input  logic [OFF_W-1:0]  offset,
    input  logic              mode,
    input  logic              oob_own,
    input  logic [WL_W-1:0]   wl,
    output logic [LANE_W-1:0] src,
    output logic              use_own
);

    localparam int ADDR_W = LANE_W + 2;
    localparam logic [LANE_W-1:0] MY_LANE = LANE_W'(LANE_ID);

    logic [ADDR_W-1:0]   byte_sum;
    logic [LANE_W-1:0]   perm_src;
    logic [LANE_W-1:0]   sub_mask;
    logic [SHUF_W-2:0]   wide_mask;
    logic [SHUF_W-1:0]   shf;
    logic                out_of_range;
    logic [LANE_W-1:0]   shuf_src;

    always_comb begin
        // byte address to lane: only the lane field of the sum matters
        byte_sum = index[ADDR_W-1:0] + offset[ADDR_W-1:0];
        perm_src = byte_sum[ADDR_W-1:2];

        // subsection mask has the low wl bits set
        sub_mask  = ~({LANE_W{1'b1}} << wl);
        wide_mask = (SHUF_W-1)'(sub_mask);

        shf          = index[SHUF_W-1:0];
        out_of_range = shf[SHUF_W-1] | (|(shf[SHUF_W-2:0] & ~wide_mask));

        // two's-complement low bits give the non-negative remainder
        shuf_src = (MY_LANE & ~sub_mask) | (shf[LANE_W-1:0] & sub_mask);

        if (mode == xlp_pkg::MODE_SHUFFLE) begin
            src     = shuf_src;
            use_own = oob_own & out_of_range;
        end else begin
            src     = perm_src;
            use_own = 1'b0;
        end
    end

endmodule

// File: rtl/xlp_gather.sv
`timescale 1ns/1ps
module xlp_gather #(
    parameter int LANES = 64,
    parameter int DW    = 32,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0]     data,
    input  logic [LANES-1:0]        active,
    input  logic [LANES*LANE_W-1:0] src_sel,
    input  logic [LANES-1:0]        use_own,
    output logic [LANES*DW-1:0]     result
);

    logic [DW-1:0] lane_val [LANES];

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            lane_val[k] = active[k] ? data[k*DW +: DW] : '0;
        end
    end

    for (genvar d = 0; d < LANES; d++) begin : g_dest
        logic [LANE_W-1:0] pick;
        logic [DW-1:0]     fetched;

        always_comb begin
            pick    = src_sel[d*LANE_W +: LANE_W];
            fetched = lane_val[pick];
            if (!active[d])
                result[d*DW +: DW] = '0;
            else if (use_own[d])
                result[d*DW +: DW] = data[d*DW +: DW];
            else
                result[d*DW +: DW] = fetched;
        end
    end

endmodule

// File: rtl/xlane_permute.sv
`timescale 1ns/1ps
module xlane_permute #(
    parameter int LANES  = 64,
    parameter int DW     = 32,
    parameter int IDX_W  = 32,
    parameter int OFF_W  = 16,
    parameter int SHUF_W = 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int WL_W   = $clog2(LANE_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [LANES*DW-1:0]    in_data,
    input  logic [LANES*IDX_W-1:0] in_index,
    input  logic [OFF_W-1:0]       in_offset,
    input  logic [LANES-1:0]       in_exec,
    input  logic [WL_W-1:0]        in_width_log2,
    input  logic                   in_mode,
    input  logic                   in_oob_own,
    input  logic                   in_wave32,
    output logic                   out_valid,
    output logic [LANES*DW-1:0]    out_data
);

    localparam int HALF = LANES / 2;
    localparam logic [LANES-1:0] UPPER_HALF = {{(LANES-HALF){1'b1}}, {HALF{1'b0}}};

    logic                     capture;
    logic [WL_W-1:0]          wl_eff;
    logic [LANES-1:0]         active;
    logic [LANES*LANE_W-1:0]  src_sel;
    logic [LANES-1:0]         use_own;
    logic [LANES*DW-1:0]      result;

    always_comb begin
        wl_eff = (in_width_log2 > WL_W'(LANE_W)) ? WL_W'(LANE_W) : in_width_log2;
        active = in_exec & ~(in_wave32 ? UPPER_HALF : '0);
    end

    xlp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .capture   (capture),
        .out_valid (out_valid)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_route
        xlp_lane_route #(
            .LANES   (LANES),
            .IDX_W   (IDX_W),
            .OFF_W   (OFF_W),
            .SHUF_W  (SHUF_W),
            .LANE_ID (i)
        ) u_route (
            .index   (in_index[i*IDX_W +: IDX_W]),
            .offset  (in_offset),
            .mode    (in_mode),
            .oob_own (in_oob_own),
            .wl      (wl_eff),
            .src     (src_sel[i*LANE_W +: LANE_W]),
            .use_own (use_own[i])
        );
    end

    xlp_gather #(
        .LANES (LANES),
        .DW    (DW)
    ) u_gather (
        .data    (in_data),
        .active  (active),
        .src_sel (src_sel),
        .use_own (use_own),
        .result  (result)
    );

    always_ff @(posedge clk) begin
        if (rst)          out_data <= '0;
        else if (capture) out_data <= result;
    end

endmodule

// File: rtl/xlane_permute_chk.sv
`timescale 1ns/1ps
module xlane_permute_chk #(
    parameter int LANES = 64,
    parameter int DW    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [LANES-1:0]    in_exec,
    input logic                in_wave32,
    input logic                out_valid,
    input logic [LANES*DW-1:0] out_data
);

    localparam int HALF = LANES / 2;

    logic [LANES-1:0] lane_zero;
    logic [LANES-1:0] lane_live;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            lane_zero[k] = (out_data[k*DW +: DW] == '0);
            lane_live[k] = in_exec[k] && !(in_wave32 && k >= HALF);
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drops_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_data_holds_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    // R6, R8: lanes outside the sampled active set come out as zero
    p_idle_lanes_zero_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((lane_zero | $past(lane_live)) == '1));

endmodule

bind xlane_permute xlane_permute_chk #(
    .LANES (LANES),
    .DW    (DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_exec   (in_exec),
    .in_wave32 (in_wave32),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/xlane_permute_test.sv
`timescale 1ns/1ps
module xlane_permute_test;

    localparam int N = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [N*32-1:0] in_data;
    logic [N*32-1:0] in_index;
    logic [15:0]     in_offset;
    logic [N-1:0]    in_exec;
    logic [2:0]      in_width_log2;
    logic            in_mode;
    logic            in_oob_own;
    logic            in_wave32;
    logic            out_valid;
    logic [N*32-1:0] out_data;

    logic [31:0] dv [N];
    logic [31:0] iv [N];
    logic [31:0] seed = 32'h1234_5678;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    xlane_permute uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_index(in_index), .in_offset(in_offset), .in_exec(in_exec),
        .in_width_log2(in_width_log2), .in_mode(in_mode), .in_oob_own(in_oob_own),
        .in_wave32(in_wave32), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic bit live(int k);
        return in_exec[k] && !(in_wave32 && k >= 32);
    endfunction

    function automatic logic [31:0] expect_lane(int i);
        int src, s, w, wl;
        logic [31:0] sum;
        if (!live(i)) return 32'h0;
        if (!in_mode) begin
            sum = iv[i] + {16'h0, in_offset};
            src = int'(sum / 4) % 64;
        end else begin
            wl = (in_width_log2 > 6) ? 6 : int'(in_width_log2);
            w  = 1 << wl;
            s  = int'($signed(iv[i][7:0]));
            if ((s < 0 || s >= w) && in_oob_own) return dv[i];
            src = (i / w) * w + (((s % w) + w) % w);
        end
        return live(src) ? dv[src] : 32'h0;
    endfunction

    task automatic pack();
        for (int k = 0; k < N; k++) begin
            in_data[k*32 +: 32]  = dv[k];
            in_index[k*32 +: 32] = iv[k];
        end
    endtask

    task automatic fill_data();
        for (int k = 0; k < N; k++) dv[k] = {8'hC3, 8'(k), rnd() [15:0] | 16'h1};
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic run_vec(string req);
        logic [31:0] exp_v [N];
        int bad;
        pack();
        for (int k = 0; k < N; k++) exp_v[k] = expect_lane(k);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        bad = -1;
        for (int k = 0; k < N; k++)
            if (bad < 0 && out_data[k*32 +: 32] !== exp_v[k]) bad = k;
        if (!out_valid || bad >= 0) begin
            errors++;
            if (bad < 0) bad = 0;
            $display("FAIL %s: lane %0d valid=%b data=%h expected valid=1 data=%h",
                     req, bad, out_valid, out_data[bad*32 +: 32], exp_v[bad]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N*32-1:0] held;
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_index = '0; in_offset = '0;
        in_exec = '1; in_width_log2 = 3'd0; in_mode = 1'b0; in_oob_own = 1'b0; in_wave32 = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1: valid=%b data_nonzero=%b expected valid=0 data=0", out_valid, |out_data);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1: after release valid=%b expected 0", out_valid);
        end

        // R2, R11: permute patterns, offsets, junk upper bits, negative addresses
        for (int p = 0; p < 6; p++) begin
            for (int o = 0; o < 4; o++) begin
                fill_data();
                for (int k = 0; k < N; k++) begin
                    case (p)
                        0: iv[k] = 32'(k * 4);
                        1: iv[k] = 32'((63 - k) * 4 + 3);
                        2: iv[k] = 32'd20;
                        3: iv[k] = rnd();
                        4: iv[k] = -32'(k * 4 + 4);
                        default: iv[k] = {rnd() [31:8], 8'(k * 12 + 1)};
                    endcase
                end
                in_offset     = (o == 0) ? 16'd0 : (o == 1) ? 16'd7 : (o == 2) ? 16'd252 : rnd() [15:0];
                in_mode       = 1'b0;
                in_oob_own    = (o >= 2);
                in_width_log2 = 3'(o + 1);
                in_exec       = '1;
                in_wave32     = 1'b0;
                run_vec((o >= 2) ? "R11 permute ignores policy" : "R2 permute");
            end
        end

        // R3, R4, R5: shuffle sweep over every width code, both policies
        for (int wl = 0; wl < 8; wl++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int b = -30; b <= 90; b += 8) begin
                    fill_data();
                    for (int k = 0; k < N; k++)
                        iv[k] = {rnd() [31:8], 8'(b + (k % 5) - 2)};
                    in_mode = 1'b1; in_oob_own = 1'(pol); in_width_log2 = 3'(wl);
                    in_exec = '1; in_wave32 = 1'b0; in_offset = rnd() [15:0];
                    run_vec(wl == 7 ? "R5 width clamp" : (pol != 0 ? "R4 own value" : "R3 wrap"));
                end
            end
        end

        // R6, R7: partial execute masks in both modes
        for (int m = 0; m < 6; m++) begin
            fill_data();
            for (int k = 0; k < N; k++) iv[k] = rnd();
            in_exec   = (m == 0) ? {32{2'b01}} : (m == 1) ? {rnd(), rnd()} : {N{1'b0}} | {rnd(), 32'hFFFF_FFFF};
            in_mode   = 1'(m % 2); in_oob_own = 1'(m > 3); in_width_log2 = 3'(m + 1);
            in_wave32 = 1'b0; in_offset = 16'(m * 5);
            run_vec("R6 R7 execute mask");
        end

        // R8: half-wave, permute wraps at 64 and upper lanes read as zero
        for (int m = 0; m < 4; m++) begin
            fill_data();
            for (int k = 0; k < N; k++) iv[k] = (m == 0) ? 32'((k + 32) * 4) : rnd();
            in_exec = (m == 3) ? {rnd(), rnd()} : '1;
            in_mode = 1'(m == 2); in_oob_own = 1'b0; in_width_log2 = 3'd6;
            in_wave32 = 1'b1; in_offset = 16'(m * 64);
            run_vec("R8 half wave");
        end

        // R9, R10: idle cycle drops valid and holds data
        held = out_data;
        in_index = ~in_index; in_data = ~in_data;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9: out_valid=%b expected 0", out_valid);
        end
        checks++;
        if (out_data !== held) begin
            errors++;
            $display("FAIL R10: out_data changed to %h expected %h", out_data[31:0], held[31:0]);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule